// File: doc/BRIEF.md
# Vectored Prioritized Interrupt Controller

This block gathers up to 77 interrupt inputs and presents a single request line to a processor. Each source carries its own trigger type, a 3-bit priority, a vector word and an enable bit. Software reaches this per-source state through a window: it first writes a source number into the select register, then reads or writes the mode, vector and command registers, which act on that source only.

A read of the acknowledge register returns the vector word of the best eligible source, clears that source's edge latch, and pushes its priority onto an internal stack of eight levels. Each end-of-interrupt write pops one level. The request line only rises for a source whose priority is strictly above the level on top of the stack, so a handler can be interrupted only by more urgent work. When nothing is eligible the acknowledge read returns a programmable spurious word. A keyed protect register can freeze the configuration.

The bus is a simple single-cycle word-addressed port with separate read and write strobes; read data is combinational on the current address.

Top module: `vpic_core`

## Requirements
- R1: After reset the request output is low, every source is disabled with mode 0 (high level, priority 0) and vector 0, the spurious word is 0, protection is off and the stack is empty.
- R2: A write to the select register (word 0) takes effect only if the value is below 77; otherwise the selection is unchanged. Reading word 0 returns the current selection.
- R3: The mode register (word 1) holds priority in bits [2:0] and type in bits [6:5]: 0 high level, 1 rising edge, 2 low level, 3 falling edge. A mode write with type 2 or 3 to a source not marked external is ignored entirely; by default sources 64 to 76 are external.
- R4: Writing bit 0 = 1 to word 5 enables the selected source, writing bit 0 = 1 to word 6 disables it; reading word 5 returns the enable bit. A disabled source never raises the request.
- R5: An edge-type source latches pending on its active edge and stays pending after the input returns; writing bit 0 = 1 to word 7 clears that latch. Reading word 7 returns the selected source's pending state.
- R6: A level-type source is pending exactly while its input is at the active level (high for type 0, low for type 2).
- R7: Among enabled pending sources above the current level, the highest priority wins; equal priorities go to the lower source number.
- R8: A read of word 3 returns the winner's vector word (programmed through word 2), clears the winner's edge latch, and pushes its priority.
- R9: The request output is high only when an enabled pending source has priority above the stack top (any priority when empty). Each write to word 4 pops one level; a pop on an empty stack has no effect. Eight nested acknowledges fit.
- R10: When no source is eligible, a read of word 3 returns the spurious word (word 8) and pushes nothing.
- R11: Writing word 9 with bits [31:8] = 0x1C7A55 sets protection to bit 0; any other value is ignored. While protected, writes to words 1, 2 and 8 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (side effects on word 3) |
| bus_addr | input | 4 | Word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| src_in | input | 77 | Synchronous interrupt inputs |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
The bench aims at the tie between two equal priorities, where a design scanning from the wrong end would hand out the higher-numbered vector. It fills the stack to all eight levels and pops it past empty, which exposes an off-by-one counter through a request that never returns or rises too early. It pulses an edge source for one cycle and checks that the latch survives until acknowledge or clear, and it tries low-level types on an internal source and configuration writes under protection, where a lax design would quietly change the readback.

// File: rtl/vpic_core.sv
module vpic_core #(
  parameter int NSRC = 77,
  parameter int NPRIO = 8,
  parameter int VW = 32,
  parameter logic [NSRC-1:0] EXT_MASK = {13'h1FFF, 64'h0},
  parameter logic [23:0] WP_KEY = 24'h1C7A55
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic [3:0]      bus_addr,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  input  logic [NSRC-1:0] src_in,
  output logic            irq_out
);
  localparam int SW  = $clog2(NSRC);
  localparam int PW  = $clog2(NPRIO);
  localparam int SIW = $clog2(NPRIO);
  localparam int CW  = $clog2(NPRIO + 1);
  localparam logic [3:0] A_SEL = 4'd0, A_MODE = 4'd1, A_VWORD = 4'd2, A_ACK = 4'd3,
    A_EOI = 4'd4, A_EN = 4'd5, A_DIS = 4'd6, A_CLR = 4'd7, A_SPUR = 4'd8, A_WP = 4'd9;

  logic [SW-1:0]   sel_q;
  logic [PW+1:0]   mode_q [NSRC];
  logic [VW-1:0]   vec_q  [NSRC];
  logic [NSRC-1:0] en_q, epend_q, act_q;
  logic [NSRC-1:0] act, pend;
  logic [VW-1:0]   spur_q;
  logic            prot_q;
  logic [PW-1:0]   stk_q [NPRIO];
  logic [CW-1:0]   cnt_q;
  logic [PW-1:0]   top;
  logic            win_ok;
  logic [SW-1:0]   win_idx;
  logic [PW-1:0]   win_pri;
  logic [PW+1:0]   mode_cur;

  wire wr_sel  = bus_wr && bus_addr == A_SEL && bus_wdata < 32'(NSRC);
  wire wr_cfg  = bus_wr && !prot_q;
  wire type_ok = EXT_MASK[sel_q] || !bus_wdata[6];
  wire ack     = bus_rd && bus_addr == A_ACK;
  wire push    = ack && win_ok;
  wire pop     = bus_wr && bus_addr == A_EOI && cnt_q != '0;

  assign top      = stk_q[SIW'(cnt_q - 1'b1)];
  assign mode_cur = mode_q[sel_q];
  assign irq_out  = win_ok;

  always_comb begin
    for (int i = 0; i < NSRC; i++) begin
      act[i]  = src_in[i] ^ mode_q[i][PW+1];
      pend[i] = mode_q[i][PW] ? epend_q[i] : act[i];
    end
  end

  always_comb begin
    win_ok = 1'b0; win_idx = '0; win_pri = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (en_q[i] && pend[i] && (cnt_q == '0 || mode_q[i][PW-1:0] > top) &&
          (!win_ok || mode_q[i][PW-1:0] >= win_pri)) begin
        win_ok  = 1'b1;
        win_idx = SW'(i);
        win_pri = mode_q[i][PW-1:0];
      end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_SEL:   bus_rdata = 32'(sel_q);
      A_MODE:  bus_rdata = 32'({mode_cur[PW+1:PW], {(5-PW){1'b0}}, mode_cur[PW-1:0]});
      A_VWORD: bus_rdata = 32'(vec_q[sel_q]);
      A_ACK:   bus_rdata = win_ok ? 32'(vec_q[win_idx]) : 32'(spur_q);
      A_EN:    bus_rdata = 32'(en_q[sel_q]);
      A_CLR:   bus_rdata = 32'(pend[sel_q]);
      A_SPUR:  bus_rdata = 32'(spur_q);
      A_WP:    bus_rdata = 32'(prot_q);
      default: bus_rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= '0; spur_q <= '0; prot_q <= 1'b0;
      en_q <= '0; epend_q <= '0; act_q <= '0; cnt_q <= '0;
      for (int i = 0; i < NSRC; i++) begin
        mode_q[i] <= '0;
        vec_q[i]  <= '0;
      end
      for (int k = 0; k < NPRIO; k++) stk_q[k] <= '0;
    end else begin
      act_q <= act;
      if (wr_sel) sel_q <= bus_wdata[SW-1:0];
      if (wr_cfg && bus_addr == A_MODE && type_ok)
        mode_q[sel_q] <= {bus_wdata[6:5], bus_wdata[PW-1:0]};
      if (wr_cfg && bus_addr == A_VWORD) vec_q[sel_q] <= bus_wdata[VW-1:0];
      if (wr_cfg && bus_addr == A_SPUR) spur_q <= bus_wdata[VW-1:0];
      if (bus_wr && bus_addr == A_WP && bus_wdata[31:8] == WP_KEY) prot_q <= bus_wdata[0];
      if (bus_wr && bus_addr == A_EN && bus_wdata[0]) en_q[sel_q] <= 1'b1;
      if (bus_wr && bus_addr == A_DIS && bus_wdata[0]) en_q[sel_q] <= 1'b0;
      for (int i = 0; i < NSRC; i++) begin
        if (mode_q[i][PW] && act[i] && !act_q[i])
          epend_q[i] <= 1'b1;
        else if ((push && win_idx == SW'(i)) ||
                 (bus_wr && bus_addr == A_CLR && bus_wdata[0] && sel_q == SW'(i)))
          epend_q[i] <= 1'b0;
      end
      if (push) begin
        stk_q[SIW'(cnt_q)] <= win_pri;
        cnt_q <= cnt_q + 1'b1;
      end else if (pop) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> cnt_q < CW'(NPRIO)); // R9
  AST_ACK_PUSHES: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> cnt_q == $past(cnt_q) + 1'b1); // R8
  AST_EOI_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_EOI && cnt_q == '0) |=> cnt_q == '0); // R9
  AST_SEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_SEL && bus_wdata >= 32'(NSRC)) |=> $stable(sel_q)); // R2
  AST_PROT_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_MODE && prot_q) |=> $stable(mode_cur)); // R11
  AST_SPUR_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_out && bus_rd && bus_addr == A_ACK) |-> bus_rdata == 32'(spur_q)); // R10
endmodule

// File: tb/vpic_core_tb.sv
module vpic_core_tb_top;
  logic clk = 0, rst_n = 0, bus_wr = 0, bus_rd = 0;
  logic [3:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [76:0] src_in = '0;
  logic irq_out;
  int checks = 0, failures = 0;
  bit done = 0;

  vpic_core dut_i (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .src_in(src_in), .irq_out(irq_out));

  always #5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(posedge clk); #1 bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1 bus_wr = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(posedge clk); #1 bus_rd = 1; bus_addr = a;
    @(negedge clk); d = bus_rdata;
    @(posedge clk); #1 bus_rd = 0;
  endtask

  task automatic chk_rd(input string req, input logic [3:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    check(req, d, exp);
  endtask

  task automatic chk_irq(input string req, input logic exp);
    @(negedge clk); check(req, 32'(irq_out), 32'(exp));
  endtask

  task automatic setup(input int s, input logic [31:0] mode, input logic [31:0] vec);
    wr(4'd0, s); wr(4'd1, mode); wr(4'd2, vec); wr(4'd5, 1);
  endtask

  task automatic t_reset();
    chk_irq("R1 irq low", 0);
    chk_rd("R1 enable", 4'd5, 0);
    chk_rd("R1 mode", 4'd1, 0);
    chk_rd("R1 spurious ack", 4'd3, 0);
    chk_rd("R1 protect", 4'd9, 0);
  endtask

  task automatic t_window();
    wr(4'd0, 5); wr(4'd1, 32'h23);
    chk_rd("R3 mode readback", 4'd1, 32'h23);
    wr(4'd0, 200);
    chk_rd("R2 out-of-range select", 4'd0, 5);
    wr(4'd1, 32'h63);
    chk_rd("R3 falling on internal ignored", 4'd1, 32'h23);
    wr(4'd1, 32'h42);
    chk_rd("R3 low level on internal ignored", 4'd1, 32'h23);
    wr(4'd0, 70); wr(4'd1, 32'h65);
    chk_rd("R3 falling on external", 4'd1, 32'h65);
  endtask

  task automatic t_edge();
    setup(5, 32'h23, 32'h500);
    @(posedge clk); #1 src_in[5] = 1;
    @(posedge clk); #1 src_in[5] = 0;
    repeat (2) @(posedge clk);
    chk_irq("R5 edge latched", 1);
    chk_rd("R5 pending read", 4'd7, 1);
    wr(4'd7, 1);
    chk_rd("R5 cleared", 4'd7, 0);
    chk_irq("R5 irq after clear", 0);
  endtask

  task automatic t_level();
    setup(70, 32'h42, 32'h700);
    chk_irq("R6 low level inactive", 0);
    @(posedge clk); #1 src_in[70] = 0;
    chk_irq("R6 low level active", 1);
    wr(4'd6, 1);
    chk_irq("R4 disabled source", 0);
    chk_rd("R4 enable bit clear", 4'd5, 0);
    wr(4'd5, 1);
    chk_irq("R4 re-enabled", 1);
    @(posedge clk); #1 src_in[70] = 1;
    chk_irq("R6 level released", 0);
  endtask

  task automatic t_priority();
    setup(10, 4, 32'h0A); setup(20, 4, 32'h14); setup(30, 6, 32'h1E);
    @(posedge clk); #1 src_in[10] = 1; src_in[20] = 1; src_in[30] = 1;
    chk_rd("R7 highest priority", 4'd3, 32'h1E);
    chk_irq("R9 lower than top blocked", 0);
    @(posedge clk); #1 src_in[30] = 0;
    wr(4'd4, 0);
    chk_irq("R9 pop reopens", 1);
    chk_rd("R7 tie lower index", 4'd3, 32'h0A);
    chk_irq("R9 equal to top blocked", 0);
    wr(4'd4, 0);
    chk_irq("R9 after pop", 1);
    @(posedge clk); #1 src_in[10] = 0; src_in[20] = 0;
    chk_irq("R7 all released", 0);
  endtask

  task automatic t_nest();
    @(posedge clk); #1 src_in[5] = 1;
    @(posedge clk); #1 src_in[5] = 0;
    chk_rd("R8 edge vector", 4'd3, 32'h500);
    wr(4'd0, 5);
    chk_rd("R8 ack clears latch", 4'd7, 0);
    @(posedge clk); #1 src_in[70] = 0;
    chk_irq("R9 prio 2 under 3 blocked", 0);
    wr(4'd4, 0);
    chk_irq("R9 prio 2 after pop", 1);
    chk_rd("R8 level vector", 4'd3, 32'h700);
    @(posedge clk); #1 src_in[70] = 1;
    wr(4'd4, 0);
    chk_irq("R9 stack drained", 0);
  endtask

  task automatic t_depth();
    for (int k = 0; k < 8; k++) setup(40 + k, k, 32'h100 + 40 + k);
    for (int k = 0; k < 8; k++) begin
      @(posedge clk); #1 src_in[40 + k] = 1;
      chk_rd("R9 nested ack", 4'd3, 32'h100 + 40 + k);
    end
    chk_irq("R9 full stack", 0);
    @(posedge clk); #1 src_in[47:40] = '0;
    for (int k = 0; k < 7; k++) wr(4'd4, 0);
    @(posedge clk); #1 src_in[40] = 1;
    chk_irq("R9 prio 0 under last level", 0);
    wr(4'd4, 0);
    chk_irq("R9 empty stack admits prio 0", 1);
    wr(4'd4, 0);
    chk_rd("R9 pop on empty harmless", 4'd3, 32'h128);
    chk_irq("R9 one level held", 0);
    @(posedge clk); #1 src_in[41] = 1;
    chk_irq("R9 prio 1 above 0", 1);
    chk_rd("R7 next vector", 4'd3, 32'h129);
    @(posedge clk); #1 src_in[41:40] = '0;
    wr(4'd4, 0); wr(4'd4, 0);
    chk_irq("R9 drained", 0);
  endtask

  task automatic t_spur();
    wr(4'd8, 32'hDEAD);
    chk_rd("R10 spurious word", 4'd3, 32'hDEAD);
    @(posedge clk); #1 src_in[40] = 1;
    chk_irq("R10 no push on spurious", 1);
    chk_rd("R10 real vector", 4'd3, 32'h128);
    @(posedge clk); #1 src_in[40] = 0;
    wr(4'd4, 0);
  endtask

  task automatic t_protect();
    wr(4'd9, 32'h12345601);
    chk_rd("R11 wrong key ignored", 4'd9, 0);
    wr(4'd9, 32'h1C7A5501);
    chk_rd("R11 key accepted", 4'd9, 1);
    wr(4'd0, 5); wr(4'd1, 32'h07); wr(4'd2, 32'hBEEF); wr(4'd8, 32'h1);
    chk_rd("R11 mode frozen", 4'd1, 32'h23);
    chk_rd("R11 vector frozen", 4'd2, 32'h500);
    chk_rd("R11 spurious frozen", 4'd8, 32'hDEAD);
    wr(4'd9, 32'h1C7A5500);
    wr(4'd1, 32'h07);
    chk_rd("R11 unprotected write", 4'd1, 32'h07);
  endtask

  initial begin
    src_in[70] = 1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset(); t_window(); t_edge(); t_level(); t_priority();
    t_nest(); t_depth(); t_spur(); t_protect();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule